// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides which of five interrupt sources an 8-bit processor core serves next. The sources are:

- a nonmaskable trap;
- three maskable restart requests, named by level 7.5, 6.5 and 5.5;
- one external request whose vector the core must fetch through an acknowledge cycle.

The block owns the per-restart masks, the global interrupt enable, the edge latch for the 7.5 input and the edge latch for the trap. It also owns the serial output bit. Every input pin, including the serial input, passes through a two-flop synchronizer before any edge or level is looked at.

The core raises `sample_i` in the cycles where an interrupt may be taken. Those are the next-to-last clock of an instruction, and any clock in a hold or halt state. If a qualified request is pending on that strobe, the block accepts it. On the next cycle it pulses `take_o` and presents either a fixed restart address on `vec_o` or the `fetch_o` flag, which tells the core to run an acknowledge cycle for the external request. Pushing the program counter and branching stay in the core.

The core also drives three single-cycle commands into the block:
- The enable and disable strobes set and clear the global enable.
- The read-mask strobe captures a status byte.
- The set-mask strobe carries a control byte.

Top module: `vec_irq_ctrl`

## Requirements
- R1: When more than one qualified request is pending at a sample strobe, exactly one is taken. The order, highest first, is trap, 7.5, 6.5, 5.5, external.
- R2: A taken trap gives vector 8'h24, 7.5 gives 8'h3C, 6.5 gives 8'h34 and 5.5 gives 8'h2C, each with `fetch_o`=0. A taken external request gives `fetch_o`=1 with `vec_o`=8'h00. `take_o`, `vec_o` and `fetch_o` are valid in the cycle after the strobe.
- R3: A request is taken only on a clock where `sample_i` is high. `take_o` is a single-cycle pulse.
- R4: A rising edge on the 7.5 input sets a latch even while 7.5 is masked. The latch clears when 7.5 is taken, or on a set-mask write with bit 4 set, or on reset.
- R5: The 6.5, 5.5 and external inputs are level-sensitive. Each is taken only if it is still high at the sample strobe. A request that falls before the strobe is lost.
- R6: The trap ignores the masks and the global enable. It is taken only if a rising edge was latched and the pin is still high at the strobe. It is not taken again until the pin has gone low and then high.
- R7: Taking any interrupt clears the global enable. The enable strobe sets it and the disable strobe clears it. The maskable sources (7.5, 6.5, 5.5, external) are taken only while it is set. A restart mask bit of 1 blocks its source; the external request has no mask.
- R8: The first read-mask after a trap is taken reports in bit 3 the enable state from before the trap. Every later read reports the current enable.
- R9: Read-mask latches a status byte into `rim_data_o`, visible in the cycle after the strobe:
  - bits 2..0: masks for 5.5, 6.5, 7.5;
  - bit 3: enable;
  - bits 6..4: pending 5.5 level, 6.5 level, 7.5 latch;
  - bit 7: synchronized serial input.
- R10: Set-mask loads bits 2..0 into the masks only when bit 3 is 1. It loads bit 7 into `sod_o` only when bit 6 is 1. Without a set-mask write the masks and `sod_o` never change.
- R11: After reset the masks are all 1, the enable and both latches are 0, `sod_o` is 0 and `take_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Nonmaskable trap request pin |
| rq75_i | input | 1 | Edge-triggered restart request, level 7.5 |
| rq65_i | input | 1 | Level restart request, level 6.5 |
| rq55_i | input | 1 | Level restart request, level 5.5 |
| ext_rq_i | input | 1 | Externally vectored request |
| sid_i | input | 1 | Serial input data |
| sample_i | input | 1 | Sampling strobe from the core |
| en_i | input | 1 | Enable-interrupts command |
| dis_i | input | 1 | Disable-interrupts command |
| rim_i | input | 1 | Read-mask command |
| sim_i | input | 1 | Set-mask command |
| sim_data_i | input | 8 | Set-mask control byte |
| take_o | output | 1 | Interrupt accepted pulse |
| vec_o | output | 8 | Restart address of the accepted source |
| fetch_o | output | 1 | Accepted source needs an acknowledge-cycle vector fetch |
| rim_data_o | output | 8 | Status byte captured by read-mask |
| sod_o | output | 1 | Serial output data |

## Verification
Each piece of internal state shows up at the ports within one or two cycles.

- **Enable.** A wrong enable shows on the very next sample strobe: a maskable request is taken or refused when it should not be. It also shows in bit 3 of the next status read.
- **7.5 latch.** A latch that fails to set or fails to clear appears in bit 6 of a status read one cycle after the command, and at the next strobe as a missed or doubled 3Ch vector.
- **Trap latch.** A trap latch that does not clear is seen as a second 24h vector on the following strobe with the pin still high.
- **Saved trap enable.** A wrong saved enable flips bit 3 of the first read after the trap.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int VEC_W   = 8;
  localparam int STAT_W  = 8;
  localparam int N_RST   = 3;

  // synchronized pin positions
  localparam int PIN_EXT  = 0;
  localparam int PIN_R55  = 1;
  localparam int PIN_R65  = 2;
  localparam int PIN_R75  = 3;
  localparam int PIN_TRAP = 4;
  localparam int PIN_SID  = 5;
  localparam int N_PINS   = 6;

  // mask bit positions (status and control bytes)
  localparam int M55 = 0;
  localparam int M65 = 1;
  localparam int M75 = 2;

  // control byte fields
  localparam int CTL_MSE    = 3;
  localparam int CTL_CLR75  = 4;
  localparam int CTL_SOE    = 6;
  localparam int CTL_SOD    = 7;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_EXT  = 3'd5
  } irq_src_e;

  typedef struct packed {
    logic trap;
    logic r75;
    logic r65;
    logic r55;
    logic ext;
  } irq_req_t;

  // fixed priority: trap, 7.5, 6.5, 5.5, external
  function automatic irq_src_e pick_src(irq_req_t r);
    irq_src_e s;
    if (r.trap)      s = SRC_TRAP;
    else if (r.r75)  s = SRC_R75;
    else if (r.r65)  s = SRC_R65;
    else if (r.r55)  s = SRC_R55;
    else if (r.ext)  s = SRC_EXT;
    else             s = SRC_NONE;
    return s;
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(irq_src_e s);
    logic [VEC_W-1:0] v;
    case (s)
      SRC_TRAP: v = VEC_W'(8'h24);
      SRC_R75:  v = VEC_W'(8'h3C);
      SRC_R65:  v = VEC_W'(8'h34);
      SRC_R55:  v = VEC_W'(8'h2C);
      default:  v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(logic sid,
                                                    logic [N_RST-1:0] pend,
                                                    logic ie,
                                                    logic [N_RST-1:0] mask);
    return {sid, pend, ie, mask};
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic rise_o,
  output logic lat_o
);
  logic lvl_d;

  assign rise_o = lvl_i & ~lvl_d;

  // a fresh edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d <= 1'b0;
      lat_o <= 1'b0;
    end else begin
      lvl_d <= lvl_i;
      if (rise_o)     lat_o <= 1'b1;
      else if (clr_i) lat_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
(
  input  logic             trap_req_i,
  input  logic             lat75_i,
  input  logic             lvl65_i,
  input  logic             lvl55_i,
  input  logic             ext_i,
  input  logic             ie_i,
  input  logic [N_RST-1:0] mask_i,
  output irq_src_e         src_o,
  output logic             any_o
);
  irq_req_t q;

  always_comb begin
    q.trap = trap_req_i;
    q.r75  = lat75_i & ~mask_i[M75] & ie_i;
    q.r65  = lvl65_i & ~mask_i[M65] & ie_i;
    q.r55  = lvl55_i & ~mask_i[M55] & ie_i;
    q.ext  = ext_i & ie_i;
  end

  assign src_o = pick_src(q);
  assign any_o = (src_o != SRC_NONE);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic              rq75_i,
  input  logic              rq65_i,
  input  logic              rq55_i,
  input  logic              ext_rq_i,
  input  logic              sid_i,
  input  logic              sample_i,
  input  logic              en_i,
  input  logic              dis_i,
  input  logic              rim_i,
  input  logic              sim_i,
  input  logic [7:0]        sim_data_i,
  output logic              take_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              fetch_o,
  output logic [STAT_W-1:0] rim_data_o,
  output logic              sod_o
);
  logic [N_PINS-1:0] raw_w, syn_w;
  logic              rise75_w, lat75_w, clr75_w;
  logic              rise_trap_w, lat_trap_w, clr_trap_w;
  logic              trap_req_w;
  irq_src_e          win_src_w;
  logic              any_w, accept_w;

  logic              ie_q, prior_ie_q, trap_note_q, sod_q;
  logic [N_RST-1:0]  mask_q;
  logic              take_q, fetch_q;
  logic [VEC_W-1:0]  vec_q;
  logic [STAT_W-1:0] rim_q;

  always_comb begin
    raw_w           = '0;
    raw_w[PIN_EXT]  = ext_rq_i;
    raw_w[PIN_R55]  = rq55_i;
    raw_w[PIN_R65]  = rq65_i;
    raw_w[PIN_R75]  = rq75_i;
    raw_w[PIN_TRAP] = trap_i;
    raw_w[PIN_SID]  = sid_i;
  end

  irqc_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_w),
    .q_o   (syn_w)
  );

  assign accept_w   = sample_i & any_w;
  assign clr75_w    = (accept_w && win_src_w == SRC_R75) ||
                      (sim_i && sim_data_i[CTL_CLR75]);
  assign clr_trap_w = accept_w && win_src_w == SRC_TRAP;

  irqc_edge_latch u_lat75 (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (syn_w[PIN_R75]),
    .clr_i  (clr75_w),
    .rise_o (rise75_w),
    .lat_o  (lat75_w)
  );

  irqc_edge_latch u_lat_trap (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (syn_w[PIN_TRAP]),
    .clr_i  (clr_trap_w),
    .rise_o (rise_trap_w),
    .lat_o  (lat_trap_w)
  );

  // trap needs both the captured edge and a still-high pin
  assign trap_req_w = lat_trap_w & syn_w[PIN_TRAP];

  irqc_arb u_arb (
    .trap_req_i (trap_req_w),
    .lat75_i    (lat75_w),
    .lvl65_i    (syn_w[PIN_R65]),
    .lvl55_i    (syn_w[PIN_R55]),
    .ext_i      (syn_w[PIN_EXT]),
    .ie_i       (ie_q),
    .mask_i     (mask_q),
    .src_o      (win_src_w),
    .any_o      (any_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q        <= 1'b0;
      prior_ie_q  <= 1'b0;
      trap_note_q <= 1'b0;
      sod_q       <= 1'b0;
      mask_q      <= '1;
      take_q      <= 1'b0;
      fetch_q     <= 1'b0;
      vec_q       <= '0;
      rim_q       <= '0;
    end else begin
      take_q  <= accept_w;
      vec_q   <= accept_w ? src_vector(win_src_w) : '0;
      fetch_q <= accept_w && (win_src_w == SRC_EXT);

      if (accept_w)   ie_q <= 1'b0;
      else if (en_i)  ie_q <= 1'b1;
      else if (dis_i) ie_q <= 1'b0;

      if (sim_i && sim_data_i[CTL_MSE]) mask_q <= sim_data_i[N_RST-1:0];
      if (sim_i && sim_data_i[CTL_SOE]) sod_q  <= sim_data_i[CTL_SOD];

      if (rim_i)
        rim_q <= pack_status(syn_w[PIN_SID],
                             {lat75_w, syn_w[PIN_R65], syn_w[PIN_R55]},
                             trap_note_q ? prior_ie_q : ie_q,
                             mask_q);

      if (clr_trap_w) begin
        trap_note_q <= 1'b1;
        prior_ie_q  <= ie_q;
      end else if (rim_i) begin
        trap_note_q <= 1'b0;
      end
    end
  end

  assign take_o     = take_q;
  assign vec_o      = vec_q;
  assign fetch_o    = fetch_q;
  assign rim_data_o = rim_q;
  assign sod_o      = sod_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sample_i,
  input logic             sim_i,
  input logic             take_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             fetch_o,
  input logic             sod_o,
  input logic             ie_q,
  input logic [N_RST-1:0] mask_q
);
  assert_take_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(sample_i));

  assert_take_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o || $past(sample_i));

  assert_fixed_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !fetch_o) |->
      (vec_o == 8'h24 || vec_o == 8'h3C || vec_o == 8'h34 || vec_o == 8'h2C));

  assert_fetch_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> (take_o && vec_o == '0));

  assert_enable_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ie_q);

  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sim_i) |-> $stable(mask_q));

  assert_sod_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sim_i) |-> $stable(sod_o));
endmodule

bind vec_irq_ctrl irqc_chk u_irqc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sample_i (sample_i),
  .sim_i    (sim_i),
  .take_o   (take_o),
  .vec_o    (vec_o),
  .fetch_o  (fetch_o),
  .sod_o    (sod_o),
  .ie_q     (ie_q),
  .mask_q   (mask_q)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_ROWS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_i = 0, rq75_i = 0, rq65_i = 0, rq55_i = 0, ext_rq_i = 0, sid_i = 0;
  logic sample_i = 0, en_i = 0, dis_i = 0, rim_i = 0, sim_i = 0;
  logic [7:0] sim_data_i = '0;
  logic take_o, fetch_o, sod_o;
  logic [7:0] vec_o, rim_data_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rq75_i(rq75_i), .rq65_i(rq65_i),
    .rq55_i(rq55_i), .ext_rq_i(ext_rq_i), .sid_i(sid_i), .sample_i(sample_i),
    .en_i(en_i), .dis_i(dis_i), .rim_i(rim_i), .sim_i(sim_i), .sim_data_i(sim_data_i),
    .take_o(take_o), .vec_o(vec_o), .fetch_o(fetch_o), .rim_data_o(rim_data_o),
    .sod_o(sod_o)
  );

  // row: [18:14] pins {trap,75,65,55,ext}, [13] enable, [12:10] masks {75,65,55},
  //      [9] expected take, [8:1] expected vector, [0] expected fetch
  localparam logic [18:0] ROWS [N_ROWS] = '{
    {5'b11111, 1'b1, 3'b000, 1'b1, 8'h24, 1'b0},
    {5'b01111, 1'b1, 3'b000, 1'b1, 8'h3C, 1'b0},
    {5'b00111, 1'b1, 3'b000, 1'b1, 8'h34, 1'b0},
    {5'b00011, 1'b1, 3'b000, 1'b1, 8'h2C, 1'b0},
    {5'b00001, 1'b1, 3'b000, 1'b1, 8'h00, 1'b1},
    {5'b01100, 1'b1, 3'b100, 1'b1, 8'h34, 1'b0},
    {5'b01111, 1'b0, 3'b000, 1'b0, 8'h00, 1'b0},
    {5'b10000, 1'b0, 3'b111, 1'b1, 8'h24, 1'b0},
    {5'b00110, 1'b1, 3'b010, 1'b1, 8'h2C, 1'b0},
    {5'b00001, 1'b1, 3'b111, 1'b1, 8'h00, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {trap_i, rq75_i, rq65_i, rq55_i, ext_rq_i, sid_i} = '0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic pulse_sim(logic [7:0] d);
    sim_data_i = d; sim_i = 1'b1;
    tick(1);
    sim_i = 1'b0; sim_data_i = '0;
  endtask

  task automatic pulse_en();
    en_i = 1'b1; tick(1); en_i = 1'b0;
  endtask

  task automatic pulse_dis();
    dis_i = 1'b1; tick(1); dis_i = 1'b0;
  endtask

  task automatic do_rim(output logic [7:0] v);
    rim_i = 1'b1; tick(1); rim_i = 1'b0;
    v = rim_data_o;
  endtask

  // strobe one cycle, return outputs seen in the following cycle
  task automatic do_sample(output logic t, output logic [7:0] v, output logic f);
    sample_i = 1'b1; tick(1); sample_i = 1'b0;
    t = take_o; v = vec_o; f = fetch_o;
  endtask

  logic t_s, f_s;
  logic [7:0] v_s, r_s;

  initial begin
    do_reset();
    // R11 reset state
    check("R11 take", take_o, 0);
    check("R11 sod", sod_o, 0);
    do_rim(r_s);
    check("R11 status", r_s, 8'h07);

    // table walk: R1 R2 R7 priority, vectors, masks, enable
    for (int k = 0; k < N_ROWS; k++) begin
      do_reset();
      pulse_sim(8'h08 | {5'b0, ROWS[k][12:10]});
      if (ROWS[k][13]) pulse_en();
      {trap_i, rq75_i, rq65_i, rq55_i, ext_rq_i} = ROWS[k][18:14];
      tick(4);
      do_sample(t_s, v_s, f_s);
      check($sformatf("R1 row %0d take", k), t_s, ROWS[k][9]);
      check($sformatf("R2 row %0d vector", k), v_s, ROWS[k][8:1]);
      check($sformatf("R2 row %0d fetch", k), f_s, ROWS[k][0]);
      tick(1);
      check($sformatf("R3 row %0d single pulse", k), take_o, 0);
    end

    // R3: pending requests without strobe are never taken
    do_reset();
    pulse_sim(8'h08); pulse_en();
    {rq65_i, ext_rq_i} = 2'b11;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      check("R3 no strobe", take_o, 0);
    end

    // R4: 7.5 edge latched while masked, cleared on service and by control bit 4
    do_reset();
    pulse_sim(8'h0C); pulse_en();
    rq75_i = 1'b1; tick(1); rq75_i = 1'b0;
    tick(4);
    do_rim(r_s);
    check("R4 latched while masked", r_s, 8'h4C);
    do_sample(t_s, v_s, f_s);
    check("R4 masked not taken", t_s, 0);
    pulse_sim(8'h08);
    do_sample(t_s, v_s, f_s);
    check("R4 taken after unmask", v_s, 8'h3C);
    do_rim(r_s);
    check("R4 cleared on service", r_s, 8'h00);
    rq75_i = 1'b1; tick(1); rq75_i = 1'b0;
    tick(4);
    pulse_sim(8'h10);
    do_rim(r_s);
    check("R4 cleared by control bit", r_s, 8'h00);

    // R5: level request dropped before strobe is lost
    do_reset();
    pulse_sim(8'h08); pulse_en();
    rq65_i = 1'b1; tick(4); rq65_i = 1'b0; tick(4);
    do_sample(t_s, v_s, f_s);
    check("R5 dropped level", t_s, 0);

    // R6: trap taken once per high period, again after low-high
    do_reset();
    trap_i = 1'b1; tick(4);
    do_sample(t_s, v_s, f_s);
    check("R6 trap taken", v_s, 8'h24);
    tick(2);
    do_sample(t_s, v_s, f_s);
    check("R6 held high not retaken", t_s, 0);
    trap_i = 1'b0; tick(4); trap_i = 1'b1; tick(4);
    do_sample(t_s, v_s, f_s);
    check("R6 retaken after new edge", v_s, 8'h24);
    trap_i = 1'b0;

    // R8: first status read after trap shows prior enable
    do_reset();
    pulse_en();
    trap_i = 1'b1; tick(4);
    do_sample(t_s, v_s, f_s);
    check("R8 trap taken", t_s, 1);
    do_rim(r_s);
    check("R8 first read prior enable", r_s, 8'h0F);
    do_rim(r_s);
    check("R8 second read current", r_s, 8'h07);
    trap_i = 1'b0;

    // R7: acceptance clears enable; disable strobe blocks
    do_reset();
    pulse_en();
    ext_rq_i = 1'b1; tick(4);
    do_sample(t_s, v_s, f_s);
    check("R7 external taken", f_s, 1);
    do_rim(r_s);
    check("R7 enable cleared", r_s[3], 0);
    do_sample(t_s, v_s, f_s);
    check("R7 blocked while disabled", t_s, 0);
    pulse_en();
    do_sample(t_s, v_s, f_s);
    check("R7 taken after re-enable", f_s, 1);
    pulse_en(); pulse_dis();
    do_sample(t_s, v_s, f_s);
    check("R7 disable strobe blocks", t_s, 0);
    ext_rq_i = 1'b0;

    // R9: status layout with serial input and level pendings
    do_reset();
    pulse_sim(8'h0A);
    {sid_i, rq65_i, rq55_i} = 3'b111; tick(4);
    do_rim(r_s);
    check("R9 status layout", r_s, 8'hB2);
    {sid_i, rq65_i, rq55_i} = 3'b000;

    // R10: control byte gating
    do_reset();
    pulse_sim(8'h05);
    do_rim(r_s);
    check("R10 masks kept without bit 3", r_s, 8'h07);
    pulse_sim(8'hC0);
    tick(1);
    check("R10 serial out set", sod_o, 1);
    pulse_sim(8'h00);
    tick(1);
    check("R10 serial out kept without bit 6", sod_o, 1);
    pulse_sim(8'h40);
    tick(1);
    check("R10 serial out cleared", sod_o, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule